// File: doc/BRIEF.md
# Branch Condition and Delay Slot Unit

This block decides whether a conditional branch is taken and chooses the next program counter for a pipeline with one branch delay slot. When a branch issues, the block tests a 4-bit condition code against the negative, zero, overflow, carry and P flags of the status word. It stores the resulting taken bit and the branch target at that moment, in program order.

The redirect is held back until the delay-slot instruction signals completion. One cycle after that completion strobe, the block pulses a program-counter load. The loaded value is the stored target when the branch was taken, and the fall-through address presented with the completion strobe otherwise.

Only one branch can be outstanding. A second issue strobe that arrives while a branch is outstanding is dropped.

Top module: `branch_slot_unit`

## Requirements
- R1: While reset is asserted and after its release, `pc_load` is 0, `slot_armed` is 0 and `pc_next` is 0 until the first redirect.
- R2: Codes 0 to 7 test one flag each: 0 carry clear, 1 carry set, 2 zero clear, 3 zero set, 4 overflow clear, 5 overflow set, 6 negative clear, 7 negative set.
- R3: Code 8 is true when carry or zero is set. Code 9 is true when carry and zero are both clear.
- R4: Code 10 is true when negative equals overflow. Code 11 is true when negative differs from overflow.
- R5: Code 12 is true when zero is clear and negative equals overflow. Code 13 is true when zero is set or negative differs from overflow.
- R6: Code 14 is always true. Code 15 is true exactly when the P flag is set.
- R7: The taken bit and the target are taken from the inputs in the cycle of an accepted issue strobe. Later changes of flags, code or target have no effect on the redirect.
- R8: If `slot_done` is high in a cycle where `slot_armed` is high, `pc_load` is high for exactly the next cycle. In that cycle `pc_next` equals the stored target if the branch was taken, and otherwise the `fallthru_pc` sampled with `slot_done`.
- R9: An issue accepted while not armed sets `slot_armed` in the next cycle. It stays set until a cycle with `slot_done` and clears after that cycle.
- R10: An issue strobe while `slot_armed` is high is ignored, including in the cycle that also carries `slot_done`. It changes neither the outstanding decision nor the target, and it does not re-arm the unit.
- R11: `slot_done` while not armed produces no `pc_load`, and `pc_next` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_code | input | 4 | Branch condition code, sampled with br_issue |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_p | input | 1 | P flag |
| br_issue | input | 1 | Branch instruction executes this cycle |
| br_target | input | ADDR_W | Branch target address |
| slot_done | input | 1 | Delay-slot instruction completes this cycle |
| fallthru_pc | input | ADDR_W | Fall-through address, sampled with slot_done |
| slot_armed | output | 1 | A branch is outstanding, waiting for its delay slot |
| pc_load | output | 1 | One-cycle strobe: load pc_next into the program counter |
| pc_next | output | ADDR_W | Redirect address |

## Verification
The bench runs all sixteen codes against all 32 flag patterns. It compares each redirect address with a condition computed from the flag formulas. A swapped pair of codes, or a wrong term in the signed comparisons, would therefore send the program counter to the fall-through address where the target was expected.

After every issue, the bench scrambles the flags and the code. A design that evaluated the condition at slot completion, rather than at issue, would then follow the scrambled values. On alternating branches, the bench sends extra issue strobes, one while armed and one in the completion cycle itself. A design that accepted them would redirect to the wrong target or stay armed.

The bench also sends a completion strobe with nothing outstanding. This catches a design that pulses `pc_load` or moves `pc_next` without a pending branch.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  // Condition code encodings (the numeric values are the interface contract)
  typedef enum logic [3:0] {
    BC_CARRY_CLR = 4'd0,
    BC_CARRY_SET = 4'd1,
    BC_ZERO_CLR  = 4'd2,
    BC_ZERO_SET  = 4'd3,
    BC_OVF_CLR   = 4'd4,
    BC_OVF_SET   = 4'd5,
    BC_NEG_CLR   = 4'd6,
    BC_NEG_SET   = 4'd7,
    BC_LOW_SAME  = 4'd8,
    BC_HIGHER    = 4'd9,
    BC_SGE       = 4'd10,
    BC_SLT       = 4'd11,
    BC_SGT       = 4'd12,
    BC_SLE       = 4'd13,
    BC_ALWAYS    = 4'd14,
    BC_PTEST     = 4'd15
  } bcu_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic p;
  } bcu_flags_t;

endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
(
  input  logic [3:0] code,
  input  bcu_flags_t flags,
  output logic       hit
);

  bcu_cond_e sel;
  logic      n_eq_v;

  assign sel    = bcu_cond_e'(code);
  assign n_eq_v = (flags.n == flags.v);

  always_comb begin
    case (sel)
      BC_CARRY_CLR: hit = ~flags.c;
      BC_CARRY_SET: hit =  flags.c;
      BC_ZERO_CLR:  hit = ~flags.z;
      BC_ZERO_SET:  hit =  flags.z;
      BC_OVF_CLR:   hit = ~flags.v;
      BC_OVF_SET:   hit =  flags.v;
      BC_NEG_CLR:   hit = ~flags.n;
      BC_NEG_SET:   hit =  flags.n;
      BC_LOW_SAME:  hit =  flags.c | flags.z;
      BC_HIGHER:    hit = ~flags.c & ~flags.z;
      BC_SGE:       hit =  n_eq_v;
      BC_SLT:       hit = ~n_eq_v;
      BC_SGT:       hit = ~flags.z & n_eq_v;
      BC_SLE:       hit =  flags.z | ~n_eq_v;
      BC_ALWAYS:    hit = 1'b1;
      BC_PTEST:     hit =  flags.p;
      default:      hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bcu_branch_latch.sv
module bcu_branch_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              take_in,
  input  logic [ADDR_W-1:0] target_in,
  input  logic              slot_done,
  output logic              armed,
  output logic              taken_q,
  output logic [ADDR_W-1:0] target_q,
  output logic              fire
);

  logic              armed_d;
  logic              capture;
  logic              taken_d;
  logic [ADDR_W-1:0] target_d;

  // Only an idle unit takes a new branch; one outstanding at a time
  assign capture = issue & ~armed;
  assign fire    = slot_done & armed;

  always_comb begin
    armed_d  = armed;
    taken_d  = taken_q;
    target_d = target_q;
    if (capture) begin
      armed_d  = 1'b1;
      taken_d  = take_in;
      target_d = target_in;
    end else if (fire) begin
      armed_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      armed <= armed_d;
      if (capture) begin
        taken_q  <= taken_d;
        target_q <= target_d;
      end
    end
  end

endmodule

// File: rtl/bcu_pc_select.sv
module bcu_pc_select #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] fallthru,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next
);

  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    pc_d = taken ? target : fallthru;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load <= 1'b0;
      pc_next <= '0;
    end else begin
      pc_load <= fire;
      if (fire) begin
        pc_next <= pc_d;
      end
    end
  end

endmodule

// File: rtl/branch_slot_unit.sv
module branch_slot_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cond_code,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic              flag_p,
  input  logic              br_issue,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              slot_done,
  input  logic [ADDR_W-1:0] fallthru_pc,
  output logic              slot_armed,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next
);

  bcu_flags_t        cur_flags;
  logic              cond_hit;
  logic              lat_taken;
  logic [ADDR_W-1:0] lat_target;
  logic              redirect_fire;

  assign cur_flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c, p: flag_p};

  bcu_cond_eval u_eval (
    .code  (cond_code),
    .flags (cur_flags),
    .hit   (cond_hit)
  );

  bcu_branch_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (br_issue),
    .take_in   (cond_hit),
    .target_in (br_target),
    .slot_done (slot_done),
    .armed     (slot_armed),
    .taken_q   (lat_taken),
    .target_q  (lat_target),
    .fire      (redirect_fire)
  );

  bcu_pc_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (redirect_fire),
    .taken    (lat_taken),
    .target   (lat_target),
    .fallthru (fallthru_pc),
    .pc_load  (pc_load),
    .pc_next  (pc_next)
  );

endmodule

// File: rtl/branch_slot_unit_chk.sv
module branch_slot_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_issue,
  input logic              slot_done,
  input logic              slot_armed,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_next,
  input logic              lat_taken,
  input logic [ADDR_W-1:0] lat_target
);

  // R8
  redirect_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && slot_armed) |=> pc_load);

  // R11
  no_spurious_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_done && slot_armed) |=> !pc_load);

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_done && slot_armed) |=> $stable(pc_next));

  // R9
  arm_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_issue && !slot_armed) |=> slot_armed);

  // R9
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_armed && !slot_done) |=> slot_armed);

  // R9
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_armed && slot_done) |=> !slot_armed);

  // R10
  target_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_armed |=> ($stable(lat_target) && $stable(lat_taken)));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

endmodule

bind branch_slot_unit branch_slot_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .br_issue   (br_issue),
  .slot_done  (slot_done),
  .slot_armed (slot_armed),
  .pc_load    (pc_load),
  .pc_next    (pc_next),
  .lat_taken  (lat_taken),
  .lat_target (lat_target)
);

// File: tb/branch_slot_unit_bench.sv
module branch_slot_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    cond_code;
  logic          flag_n, flag_z, flag_v, flag_c, flag_p;
  logic          br_issue;
  logic [AW-1:0] br_target;
  logic          slot_done;
  logic [AW-1:0] fallthru_pc;
  logic          slot_armed;
  logic          pc_load;
  logic [AW-1:0] pc_next;

  int n_run  = 0;
  int n_fail = 0;
  logic [AW-1:0] last_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_slot_unit #(.ADDR_W(AW)) u_branch_slot_unit (
    .clk(clk), .rst_n(rst_n), .cond_code(cond_code),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .flag_p(flag_p),
    .br_issue(br_issue), .br_target(br_target), .slot_done(slot_done),
    .fallthru_pc(fallthru_pc), .slot_armed(slot_armed), .pc_load(pc_load), .pc_next(pc_next)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fl = {n, z, v, c, p}
  function automatic logic ref_cond(input logic [3:0] code, input logic [4:0] fl);
    logic n, z, v, c, p;
    {n, z, v, c, p} = fl;
    case (code)
      4'd0:  return !c;
      4'd1:  return c;
      4'd2:  return !z;
      4'd3:  return z;
      4'd4:  return !v;
      4'd5:  return v;
      4'd6:  return !n;
      4'd7:  return n;
      4'd8:  return c || z;
      4'd9:  return !c && !z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return p;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] code);
    if (code < 8)       return "R2";
    else if (code < 10) return "R3";
    else if (code < 12) return "R4";
    else if (code < 14) return "R5";
    else                return "R6";
  endfunction

  task automatic set_flags(input logic [4:0] fl);
    {flag_n, flag_z, flag_v, flag_c, flag_p} = fl;
  endtask

  task automatic run_branch(input logic [3:0] code, input logic [4:0] fl,
                            input logic [AW-1:0] tgt, input logic [AW-1:0] fall,
                            input logic extra);
    logic [AW-1:0] exp_pc;
    exp_pc = ref_cond(code, fl) ? tgt : fall;
    @(negedge clk);
    cond_code = code; set_flags(fl); br_issue = 1'b1; br_target = tgt;
    @(negedge clk);
    check("R9 armed after issue", AW'(slot_armed), AW'(1));
    br_issue = extra; br_target = ~tgt; cond_code = ~code; set_flags(~fl);
    @(negedge clk);
    check("R8 no early load", AW'(pc_load), AW'(0));
    br_issue = extra; slot_done = 1'b1; fallthru_pc = fall;
    @(negedge clk);
    br_issue = 1'b0; slot_done = 1'b0; fallthru_pc = ~fall;
    check("R8 load pulse", AW'(pc_load), AW'(1));
    check({req_of(code), " R7 redirect address"}, pc_next, exp_pc);
    @(negedge clk);
    check("R8 single pulse", AW'(pc_load), AW'(0));
    check(extra ? "R10 ignored issue no rearm" : "R9 cleared", AW'(slot_armed), AW'(0));
    last_pc = exp_pc;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cond_code = '0; set_flags('0); br_issue = 1'b0;
    br_target = '0; slot_done = 1'b0; fallthru_pc = '0;
    repeat (3) @(negedge clk);
    check("R1 reset load", AW'(pc_load), AW'(0));
    check("R1 reset armed", AW'(slot_armed), AW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release pc", pc_next, '0);
    check("R1 after release armed", AW'(slot_armed), AW'(0));

    for (int code = 0; code < 16; code++) begin
      for (int fl = 0; fl < 32; fl++) begin
        run_branch(4'(code), 5'(fl),
                   32'h4000_0000 | (code << 8) | (fl << 2),
                   32'h8000_0000 | (code << 12) | (fl << 4) | 32'h1,
                   1'(fl ^ code));
      end
    end

    // R11: slot completion with nothing outstanding
    @(negedge clk);
    slot_done = 1'b1; fallthru_pc = 32'hDEAD_0000;
    @(negedge clk);
    slot_done = 1'b0;
    check("R11 no load when idle", AW'(pc_load), AW'(0));
    check("R11 pc held", pc_next, last_pc);
    @(negedge clk);
    check("R11 still no load", AW'(pc_load), AW'(0));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule